// File: doc/BRIEF.md
# Bridge Configuration Write Sequencer

This block brings up an external display bridge after reset by driving a byte-write port toward an SMBus/I2C master. On a start pulse it first halts the bridge's internal firmware, then waits a long settle interval measured in millisecond ticks. Next it programs a fixed, ordered set of bridge registers. Each register is reached indirectly: one bus write puts the register index into an index location, and a second write puts the value into a data location. The last step restarts the firmware.

The values for the power-sequence timing, spread-spectrum and lane-swap registers come in on static configuration inputs. These are computed elsewhere and held steady while the block is busy. The tail of the list is a fixed group of constants. Every bus write waits for the master to acknowledge or reject it. A rejection aborts the run and raises a sticky error flag.

Top module: `bridge_cfg_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o`, `err_o` and `wr_req_o` are low.
- R2: The first write after an accepted start carries command `FW_CTRL_CMD` (default 0x6F) and data 0x01, which halts the firmware.
- R3: After the halt write is acknowledged, no request is raised until `SETTLE_MS` (default 60) `tick_ms_i` pulses have been counted. The next request appears in the cycle after the clock edge that samples the last of those ticks. Ticks outside this wait have no effect.
- R4: Each register setting is two writes: command `IDX_CMD` (default 0xF5) with the register index, then command `DATA_CMD` (default 0xF4) with the value.
- R5: Settings go out in this order. Registers 0x32 to 0x38 take bytes 0 to 6 of `timing_val_i`, where byte k is bits [8k+7:8k]. Register 0x39 takes `ssc_val_i[7:0]` and 0x3A takes `ssc_val_i[15:8]`. Register 0x3B takes `swap_val_i`. A full run has 36 writes.
- R6: After the lane-swap register come 0x3C=0x06, 0x3D=0x38, 0x3E=0x73 and 0x3F=0x33. Then register 0x06 is written three times, with 0x90, 0xB0 and 0x80 in that order.
- R7: The final write carries `FW_CTRL_CMD` with data 0x00. In the cycle after its acknowledge, `done_o` is high for exactly one cycle and `busy_o` is low.
- R8: A request stays high with stable command and data until it is acknowledged or rejected. After an acknowledge, `wr_req_o` is low for exactly one cycle before the next request.
- R9: A rejection (`wr_nack_i`) of any write ends the run with no further writes and no `done_o`. `err_o` goes high in the next cycle and stays high until the next accepted start clears it.
- R10: A start pulse while `busy_o` is high is ignored.
- R11: `busy_o` is high from the cycle after an accepted start until the run ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request pulse |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| timing_val_i | input | 56 | Power-sequence register values, byte k for register 0x32+k |
| ssc_val_i | input | 16 | Spread-spectrum register values for 0x39 (low byte) and 0x3A (high byte) |
| swap_val_i | input | 8 | Lane-swap register value |
| wr_req_o | output | 1 | Byte-write request toward the bus master |
| wr_cmd_o | output | 8 | Command byte of the write |
| wr_data_o | output | 8 | Data byte of the write |
| wr_ack_i | input | 1 | Write accepted, one cycle |
| wr_nack_i | input | 1 | Write rejected, one cycle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when a run completes |
| err_o | output | 1 | Sticky abort flag |

## Verification
The hardest behaviour to reach from the ports is the edge of the settle window. Ticks only count during the wait, so the bench runs one sequence with a tick on every cycle and another with sparse ticks. In both, the release lands exactly one cycle after the closing tick. Rejection is placed both on the halt write and in the middle of the index/data pairs, so that an abort from the pre-settle phase and from the list phase are both seen. A second start is injected partway through a run to show that no second sequence starts.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  localparam int unsigned NUM_TIMING = 7;
  localparam int unsigned NUM_SSC    = 2;
  localparam int unsigned NUM_DEF    = 4;
  localparam int unsigned NUM_REPEAT = 3;
  localparam int unsigned SWAP_IDX   = NUM_TIMING + NUM_SSC;
  localparam int unsigned DEF_IDX    = SWAP_IDX + 1;
  localparam int unsigned REPEAT_IDX = DEF_IDX + NUM_DEF;
  localparam int unsigned NUM_SET    = REPEAT_IDX + NUM_REPEAT;
  localparam int unsigned NUM_STEP   = 2 * NUM_SET + 2;

  localparam logic [7:0] TIMING_BASE = 8'h32;
  localparam logic [7:0] SSC_BASE    = 8'h39;
  localparam logic [7:0] SWAP_REG    = 8'h3B;
  localparam logic [7:0] DEF_BASE    = 8'h3C;
  localparam logic [7:0] REPEAT_REG  = 8'h06;
  localparam logic [7:0] FW_HALT     = 8'h01;
  localparam logic [7:0] FW_RUN      = 8'h00;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_GAP, ST_SETTLE} seq_state_e;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] data;
  } bus_wr_t;

  function automatic logic [7:0] def_val(int unsigned i);
    case (i)
      0:       return 8'h06;
      1:       return 8'h38;
      2:       return 8'h73;
      3:       return 8'h33;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] repeat_val(int unsigned i);
    case (i)
      0:       return 8'h90;
      1:       return 8'hB0;
      2:       return 8'h80;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcs_step_rom.sv
`timescale 1ns/1ps
module bcs_step_rom
  import bcs_pkg::*;
#(
  parameter logic [7:0] FW_CTRL_CMD = 8'h6F,
  parameter logic [7:0] IDX_CMD     = 8'hF5,
  parameter logic [7:0] DATA_CMD    = 8'hF4,
  parameter int unsigned SW         = 6
) (
  input  logic [SW-1:0]             step_i,
  input  logic [8*NUM_TIMING-1:0]   timing_val_i,
  input  logic [8*NUM_SSC-1:0]      ssc_val_i,
  input  logic [7:0]                swap_val_i,
  output bus_wr_t                   wr_o
);
  localparam int unsigned LAST = NUM_STEP - 1;

  logic [7:0] set_reg [NUM_SET];
  logic [7:0] set_val [NUM_SET];

  for (genvar g = 0; g < NUM_TIMING; g++) begin : g_timing
    assign set_reg[g] = TIMING_BASE + 8'(g);
    assign set_val[g] = timing_val_i[8*g +: 8];
  end

  for (genvar g = 0; g < NUM_SSC; g++) begin : g_ssc
    assign set_reg[NUM_TIMING+g] = SSC_BASE + 8'(g);
    assign set_val[NUM_TIMING+g] = ssc_val_i[8*g +: 8];
  end

  assign set_reg[SWAP_IDX] = SWAP_REG;
  assign set_val[SWAP_IDX] = swap_val_i;

  for (genvar g = 0; g < NUM_DEF; g++) begin : g_def
    assign set_reg[DEF_IDX+g] = DEF_BASE + 8'(g);
    assign set_val[DEF_IDX+g] = def_val(g);
  end

  for (genvar g = 0; g < NUM_REPEAT; g++) begin : g_rep
    assign set_reg[REPEAT_IDX+g] = REPEAT_REG;
    assign set_val[REPEAT_IDX+g] = repeat_val(g);
  end

  // step 0 halts, last step restarts, odd/even steps in between are index/data
  logic [SW-1:0] rel;
  logic [SW-2:0] sel;
  assign rel = step_i - SW'(1);
  assign sel = rel[SW-1:1];

  always_comb begin
    wr_o.cmd  = FW_CTRL_CMD;
    wr_o.data = FW_HALT;
    if (step_i == SW'(LAST)) begin
      wr_o.data = FW_RUN;
    end else if (step_i != '0) begin
      if (!rel[0]) begin
        wr_o.cmd  = IDX_CMD;
        wr_o.data = set_reg[sel];
      end else begin
        wr_o.cmd  = DATA_CMD;
        wr_o.data = set_val[sel];
      end
    end
  end
endmodule

// File: rtl/bcs_settle_timer.sv
`timescale 1ns/1ps
module bcs_settle_timer #(
  parameter int unsigned SETTLE_MS = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned CW = (SETTLE_MS > 1) ? $clog2(SETTLE_MS) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + CW'(1);
  end

  assign expired_o = run_i && tick_i && (cnt_q == CW'(SETTLE_MS - 1));
endmodule

// File: rtl/bcs_ctrl.sv
`timescale 1ns/1ps
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int unsigned SW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ack_i,
  input  logic          nack_i,
  input  logic          settled_i,
  output logic [SW-1:0] step_o,
  output logic          req_o,
  output logic          settle_run_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int unsigned LAST = NUM_STEP - 1;

  seq_state_e    state_q;
  logic [SW-1:0] step_q;
  logic          done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_ISSUE;
            step_q  <= '0;
            err_q   <= 1'b0;
          end
        end
        ST_ISSUE: begin
          if (nack_i) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end else if (ack_i) begin
            step_q <= step_q + SW'(1);
            if (step_q == '0) begin
              state_q <= ST_SETTLE;
            end else if (step_q == SW'(LAST)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP:    state_q <= ST_ISSUE;
        ST_SETTLE: if (settled_i) state_q <= ST_ISSUE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign step_o       = step_q;
  assign req_o        = (state_q == ST_ISSUE);
  assign settle_run_o = (state_q == ST_SETTLE);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/bridge_cfg_seq.sv
`timescale 1ns/1ps
module bridge_cfg_seq
  import bcs_pkg::*;
#(
  parameter int unsigned SETTLE_MS   = 60,
  parameter logic [7:0]  FW_CTRL_CMD = 8'h6F,
  parameter logic [7:0]  IDX_CMD     = 8'hF5,
  parameter logic [7:0]  DATA_CMD    = 8'hF4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        tick_ms_i,
  input  logic [55:0] timing_val_i,
  input  logic [15:0] ssc_val_i,
  input  logic [7:0]  swap_val_i,
  output logic        wr_req_o,
  output logic [7:0]  wr_cmd_o,
  output logic [7:0]  wr_data_o,
  input  logic        wr_ack_i,
  input  logic        wr_nack_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int unsigned SW = $clog2(NUM_STEP);

  logic [SW-1:0] step;
  logic          settle_run, settled;
  bus_wr_t       wr;

  bcs_ctrl #(.SW(SW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .ack_i        (wr_ack_i),
    .nack_i       (wr_nack_i),
    .settled_i    (settled),
    .step_o       (step),
    .req_o        (wr_req_o),
    .settle_run_o (settle_run),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  bcs_settle_timer #(.SETTLE_MS(SETTLE_MS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (settle_run),
    .tick_i    (tick_ms_i),
    .expired_o (settled)
  );

  bcs_step_rom #(
    .FW_CTRL_CMD (FW_CTRL_CMD),
    .IDX_CMD     (IDX_CMD),
    .DATA_CMD    (DATA_CMD),
    .SW          (SW)
  ) u_rom (
    .step_i       (step),
    .timing_val_i (timing_val_i),
    .ssc_val_i    (ssc_val_i),
    .swap_val_i   (swap_val_i),
    .wr_o         (wr)
  );

  assign wr_cmd_o  = wr.cmd;
  assign wr_data_o = wr.data;
endmodule

// File: rtl/bcs_checker.sv
`timescale 1ns/1ps
module bcs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       wr_req_o,
  input logic [7:0] wr_cmd_o,
  input logic [7:0] wr_data_o,
  input logic       wr_ack_i,
  input logic       wr_nack_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o
);
  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i && !wr_nack_i |=> wr_req_o && $stable(wr_cmd_o) && $stable(wr_data_o));

  // R8
  req_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_ack_i |=> !wr_req_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !err_o);

  // R9
  nack_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_nack_i |=> !busy_o && err_o && !done_o);

  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o);

  // R11
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> busy_o);

  // R2
  first_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> wr_req_o && wr_data_o == 8'h01);
endmodule

bind bridge_cfg_seq bcs_checker u_chk (.*);

// File: tb/bridge_cfg_seq_tb.sv
`timescale 1ns/1ps
module bridge_cfg_seq_tb;
  localparam int         SETTLE = 60;
  localparam logic [7:0] FW  = 8'h6F;
  localparam logic [7:0] IDX = 8'hF5;
  localparam logic [7:0] DAT = 8'hF4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, tick_i = 1'b0, ack = 1'b0, nack = 1'b0;
  logic [55:0] tv = '0;
  logic [15:0] sv = '0;
  logic [7:0]  wv = '0;
  logic        req, busy, done, err;
  logic [7:0]  cmd, data;

  always #2 clk = ~clk;

  bridge_cfg_seq #(.SETTLE_MS(SETTLE), .FW_CTRL_CMD(FW), .IDX_CMD(IDX), .DATA_CMD(DAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .tick_ms_i(tick_i),
    .timing_val_i(tv), .ssc_val_i(sv), .swap_val_i(wv),
    .wr_req_o(req), .wr_cmd_o(cmd), .wr_data_o(data),
    .wr_ack_i(ack), .wr_nack_i(nack),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference model: expected write list and behavioural state
  logic [7:0] q_cmd[$];
  logic [7:0] q_dat[$];
  int m_st = 0, m_pos = 0, m_ticks = 0;
  bit m_done = 0, m_err = 0;

  function automatic void build();
    logic [7:0] dv[7] = '{8'h06, 8'h38, 8'h73, 8'h33, 8'h90, 8'hB0, 8'h80};
    logic [7:0] dr[7] = '{8'h3C, 8'h3D, 8'h3E, 8'h3F, 8'h06, 8'h06, 8'h06};
    q_cmd.delete(); q_dat.delete();
    q_cmd.push_back(FW); q_dat.push_back(8'h01);
    for (int k = 0; k < 7; k++) begin
      q_cmd.push_back(IDX); q_dat.push_back(8'h32 + 8'(k));
      q_cmd.push_back(DAT); q_dat.push_back(tv[8*k +: 8]);
    end
    q_cmd.push_back(IDX); q_dat.push_back(8'h39);
    q_cmd.push_back(DAT); q_dat.push_back(sv[7:0]);
    q_cmd.push_back(IDX); q_dat.push_back(8'h3A);
    q_cmd.push_back(DAT); q_dat.push_back(sv[15:8]);
    q_cmd.push_back(IDX); q_dat.push_back(8'h3B);
    q_cmd.push_back(DAT); q_dat.push_back(wv);
    for (int k = 0; k < 7; k++) begin
      q_cmd.push_back(IDX); q_dat.push_back(dr[k]);
      q_cmd.push_back(DAT); q_dat.push_back(dv[k]);
    end
    q_cmd.push_back(FW); q_dat.push_back(8'h00);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_pos = 0; m_ticks = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (start_i) begin build(); m_st = 1; m_pos = 0; m_err = 0; end
        1: begin
          if (nack) begin m_st = 0; m_err = 1; end
          else if (ack) begin
            if (m_pos == 0) begin m_st = 3; m_ticks = 0; end
            else if (m_pos == q_cmd.size() - 1) begin m_st = 0; m_done = 1; end
            else m_st = 2;
            m_pos++;
          end
        end
        2: m_st = 1;
        default: if (tick_i) begin
          if (m_ticks == SETTLE - 1) m_st = 1;
          else m_ticks++;
        end
      endcase
    end
  end

  function automatic string data_tag(int pos);
    if (pos == 0) return "R2";
    if (pos == 35) return "R7";
    if (pos <= 20) return "R5";
    return "R6";
  endfunction

  task automatic compare();
    chk(busy == (m_st != 0), "R11", "busy", busy, m_st != 0);
    chk(req == (m_st == 1), (m_st == 3) ? "R3" : "R8", "req", req, m_st == 1);
    if (m_st == 1 && req) begin
      chk(cmd == q_cmd[m_pos], (m_pos == 0 || m_pos == 35) ? data_tag(m_pos) : "R4",
          "cmd", cmd, q_cmd[m_pos]);
      chk(data == q_dat[m_pos], data_tag(m_pos), "data", data, q_dat[m_pos]);
    end
    chk(done == m_done, "R7", "done", done, m_done);
    chk(err == m_err, "R9", "err", err, m_err);
  endtask

  // responder and per-cycle driver
  int ack_lat = 0, nack_at = -1, wcount = 0, lat_cnt = 0, tick_gap = 3, cyc = 0, done_cnt = 0;

  task automatic cycle(input bit st);
    @(negedge clk);
    compare();
    if (done) done_cnt++;
    start_i = st;
    cyc++;
    tick_i = (cyc % tick_gap) == 0;
    ack = 0; nack = 0;
    if (req) begin
      if (lat_cnt == ack_lat) begin
        if (wcount == nack_at) nack = 1; else ack = 1;
        wcount++;
        lat_cnt = 0;
      end else lat_cnt++;
    end
  endtask

  task automatic run(input int lat, input int gap, input int nk, input int extra);
    int n;
    ack_lat = lat; tick_gap = gap; nack_at = nk;
    wcount = 0; lat_cnt = 0; done_cnt = 0;
    cycle(1);
    n = 0;
    do begin
      cycle(n == extra);
      n++;
    end while ((busy || n < 2) && n < 20000);
    repeat (3) cycle(0);
    if (nk < 0) begin
      chk(wcount == 36, "R5", "write count", wcount, 36);
      chk(done_cnt == 1, "R7", "done pulses", done_cnt, 1);
      chk(err == 0, "R9", "err after clean run", err, 0);
    end else begin
      chk(wcount == nk + 1, "R9", "writes before abort", wcount, nk + 1);
      chk(done_cnt == 0, "R9", "done after abort", done_cnt, 0);
      chk(err == 1, "R9", "err sticky", err, 1);
    end
    chk(busy == 0, "R10", "idle after run", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && err == 0 && req == 0, "R1", "outputs in reset",
        {busy, done, err, req}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0 && req == 0, "R1", "outputs after reset",
        {busy, done, err, req}, 0);

    tv = 56'h07_06_05_04_03_02_01; sv = 16'h1F_A0; wv = 8'h04;
    run(0, 3, -1, -1);
    tv = 56'hF0_E1_D2_C3_B4_A5_96; sv = 16'h16_A0; wv = 8'hB4;
    run(3, 1, -1, 10);                 // R10: second start mid-run, R3 tick every cycle
    run(1, 2, 10, -1);                 // R9 abort in list phase
    chk(err == 1, "R9", "err held while idle", err, 1);
    run(0, 1, 0, -1);                  // R9 abort on halt write
    tv = 56'h55_AA_55_AA_55_AA_55; sv = 16'h00_00; wv = 8'h8C;
    run(2, 4, -1, 120);                // clears err, R10 start during settle

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule